// File: doc/BRIEF.md
# Serial Audio Port with Idle Status

This block is a two-channel serial audio shift engine in the style of I2S. It moves fixed-length system words between parallel data registers and a single serial data line, paced by a bit clock and a word-select line. As bus master it makes the bit clock and word select from the system clock. As slave it follows a bit clock and word select that arrive from outside. In both roles it can transmit or receive. Data goes MSB first. Outgoing bits change on the falling bit-clock edge, and incoming bits are sampled on the rising edge.

Two read-only status flags come with the engine. The word-number flag tells software which channel slot the data registers refer to. It follows the internal transfers between the shift register and the data registers, not software accesses. The idle flag shows that bus activity has ended cleanly. Clearing the enable never cuts a word short. The engine always finishes the system word in progress first, and the flag rises only at that word boundary. Mode inputs are expected to change only while the idle flag is high.

Top module: `serial_audio_port`

## Requirements
- R1: After reset, idle and wordNo read 1, and sckOut, wsOut, sdOut and rxData read 0.
- R2: As master, the bit clock runs with a period of 2*HALF_CYCLES system clocks. It is low for the first half of each bit, counted from the cycle after enable is seen. wsOut is 0 during channel-0 words and 1 during channel-1 words. It toggles every WORD_BITS bits, starting with channel 0.
- R3: As transmitter, the word held in the transmit data register (loaded by txWrite) is copied into the shift register at each word start. It is driven on sdOut MSB first, and the next bit appears at each falling bit-clock edge.
- R4: As receiver, sdIn is sampled at each rising bit-clock edge, MSB first. rxData takes the complete word at the falling edge that ends the word.
- R5: In receive mode, wordNo is updated with each rxData load to the channel of that word (0 or 1), and stays unchanged between loads.
- R6: In transmit mode, wordNo is updated with each copy into the shift register. It becomes the channel that must be written next: 1 after a channel-0 word is copied, 0 after a channel-1 word is copied.
- R7: idle drops to 0 when the engine starts on an enable of 1, and stays 0 while the bus is active.
- R8: After enable is cleared, the word in progress completes in full. idle rises only at that word's closing falling edge. As master, sckOut and wsOut then stay at 0.
- R9: As slave, the engine starts only at a falling bit-clock edge where word select is 0 and was 1 at the previous falling edge. Before such an edge, idle stays 1.
- R10: As slave, if the external bit clock stops before the current word completes, idle stays 0 until the word is finished.
- R11: In slave mode sckOut and wsOut stay 0. sdOut is 0 whenever the engine is idle or receiving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; clearing it stops at the next word boundary |
| isMaster | input | 1 | 1 = generate bit clock and word select, 0 = follow external ones |
| isTx | input | 1 | 1 = transmit, 0 = receive |
| txWrite | input | 1 | Write strobe for the transmit data register |
| txData | input | WORD_BITS | Data for the transmit data register |
| rxData | output | WORD_BITS | Receive data register |
| wordNo | output | 1 | Word-number status flag |
| idle | output | 1 | Idle status flag |
| sckOut | output | 1 | Bit clock driven as master |
| wsOut | output | 1 | Word select driven as master |
| sdOut | output | 1 | Serial data out |
| sckIn | input | 1 | External bit clock (slave) |
| wsIn | input | 1 | External word select (slave) |
| sdIn | input | 1 | Serial data in |

## Verification
If the bit counter or channel register is wrong, the effect shows at once. As master, it appears within one bit period as a misplaced sckOut or wsOut edge, or a wrong sdOut bit. As receiver, it appears at the next word boundary as a wrong rxData or wordNo. A wrong stop decision shows as idle rising mid-word, or never rising, within one system word after enable falls. The slave stall case is the one where a stuck-active engine can only be seen while the external clock is held. That case is probed with the clock frozen for many cycles.

// File: rtl/sap_pkg.sv
package sap_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;    // copy transmit register into shift register
    logic shift;   // advance transmit shift register by one bit
    logic sample;  // shift one received bit in
    logic commit;  // move received word to rxData
  } sapStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sapState_t;

endpackage

// File: rtl/sap_ctrl.sv
module sap_ctrl
  import sap_pkg::*;
#(
  parameter int WORD_BITS   = 32,
  parameter int HALF_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        isMaster,
  input  logic        isTx,
  input  logic        sckIn,
  input  logic        wsIn,
  input  logic        sdIn,
  output sapStrobes_t strobes,
  output logic        sdSample,
  output logic        running,
  output logic        sckOut,
  output logic        wsOut,
  output logic        wordNo,
  output logic        idle
);

  localparam int BIT_W = (WORD_BITS > 2) ? $clog2(WORD_BITS) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);

  sapState_t        state;
  logic [BIT_W-1:0] bitCnt;
  logic             channel;
  logic             sckReg;
  logic             sckSync, sckPrev, wsSync, sdSync, wsAtFall;
  logic             slvRise, slvFall, slvFrameStart;
  logic             mstTick, mstRise, mstFall;
  logic             riseEv, fallEv, lastBit, wordEnd, startEv;

  // Slave inputs: one register stage, plus edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= 1'b0;
      sckPrev  <= 1'b0;
      wsSync   <= 1'b0;
      sdSync   <= 1'b0;
      wsAtFall <= 1'b0;
    end else begin
      sckSync <= sckIn;
      sckPrev <= sckSync;
      wsSync  <= wsIn;
      sdSync  <= sdIn;
      if (slvFall) wsAtFall <= wsSync;
    end
  end

  assign running       = (state == ST_RUN);
  assign slvRise       = !isMaster && !sckPrev && sckSync;
  assign slvFall       = !isMaster && sckPrev && !sckSync;
  assign slvFrameStart = slvFall && !wsSync && wsAtFall;
  assign startEv       = !running && enable && (isMaster || slvFrameStart);

  // Master bit-clock pacing; a divider only when a half bit spans several cycles
  generate
    if (HALF_CYCLES == 1) begin : g_noDiv
      assign mstTick = isMaster && running;
    end else begin : g_div
      localparam int HW = $clog2(HALF_CYCLES);
      logic [HW-1:0] halfCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   halfCnt <= '0;
        else if (!running || mstTick) halfCnt <= '0;
        else if (isMaster)           halfCnt <= halfCnt + HW'(1);
      end
      assign mstTick = isMaster && running && (halfCnt == HW'(HALF_CYCLES - 1));
    end
  endgenerate

  assign mstRise  = mstTick && !sckReg;
  assign mstFall  = mstTick && sckReg;
  assign riseEv   = running && (mstRise || slvRise);
  assign fallEv   = running && (mstFall || slvFall);
  assign lastBit  = (bitCnt == LAST_BIT);
  assign wordEnd  = fallEv && lastBit;
  assign sdSample = isMaster ? sdIn : sdSync;

  always_comb begin
    strobes        = '0;
    strobes.load   = startEv || (wordEnd && enable);
    strobes.shift  = fallEv && !lastBit;
    strobes.sample = riseEv;
    strobes.commit = wordEnd && !isTx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      channel <= 1'b0;
      sckReg  <= 1'b0;
      idle    <= 1'b1;
      wordNo  <= 1'b1;
    end else begin
      if (startEv) begin
        state   <= ST_RUN;
        bitCnt  <= '0;
        channel <= 1'b0;
        sckReg  <= 1'b0;
        idle    <= 1'b0;
      end else if (running) begin
        if (mstTick) sckReg <= !sckReg;
        if (fallEv) bitCnt <= lastBit ? '0 : bitCnt + BIT_W'(1);
        if (wordEnd) begin
          if (enable) begin
            channel <= !channel;
          end else begin
            state   <= ST_IDLE;
            channel <= 1'b0;
            idle    <= 1'b1;
          end
        end
      end
      // Word number follows internal transfers only
      if (strobes.load && isTx)  wordNo <= startEv ? 1'b1 : channel;
      else if (strobes.commit)   wordNo <= channel;
    end
  end

  assign sckOut = isMaster && sckReg;
  assign wsOut  = isMaster && running && channel;

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> (!sckOut && !wsOut)); // R8
  AST_IDLE_RISE_AT_WORD_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idle) |-> ($past(wordEnd) && !$past(enable))); // R8
  AST_IDLE_FALL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(idle) |-> $past(enable)); // R7
  AST_WORDNO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.commit) |=> $stable(wordNo)); // R5
  AST_WS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && !$stable(wsOut)) |-> $past(wordEnd)); // R2

endmodule

// File: rtl/sap_datapath.sv
module sap_datapath
  import sap_pkg::*;
#(
  parameter int WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sapStrobes_t          strobes,
  input  logic                 txWrite,
  input  logic [WORD_BITS-1:0] txData,
  input  logic                 sdSample,
  input  logic                 isTx,
  input  logic                 running,
  output logic                 sdOut,
  output logic [WORD_BITS-1:0] rxData
);

  logic [WORD_BITS-1:0] txReg;
  logic [WORD_BITS-1:0] txShift;
  logic [WORD_BITS-1:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg   <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
    end else begin
      if (txWrite)             txReg   <= txData;
      if (strobes.load)        txShift <= txReg;
      else if (strobes.shift)  txShift <= {txShift[WORD_BITS-2:0], 1'b0};
      if (strobes.sample)      rxShift <= {rxShift[WORD_BITS-2:0], sdSample};
      if (strobes.commit)      rxData  <= rxShift;
    end
  end

  assign sdOut = running && isTx && txShift[WORD_BITS-1];

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.shift, strobes.sample})); // R3

endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
  import sap_pkg::*;
#(
  parameter int WORD_BITS   = 32,
  parameter int HALF_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic                 isMaster,
  input  logic                 isTx,
  input  logic                 txWrite,
  input  logic [WORD_BITS-1:0] txData,
  output logic [WORD_BITS-1:0] rxData,
  output logic                 wordNo,
  output logic                 idle,
  output logic                 sckOut,
  output logic                 wsOut,
  output logic                 sdOut,
  input  logic                 sckIn,
  input  logic                 wsIn,
  input  logic                 sdIn
);

  sapStrobes_t strobes;
  logic        sdSample;
  logic        running;

  sap_ctrl #(
    .WORD_BITS  (WORD_BITS),
    .HALF_CYCLES(HALF_CYCLES)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .isMaster(isMaster),
    .isTx    (isTx),
    .sckIn   (sckIn),
    .wsIn    (wsIn),
    .sdIn    (sdIn),
    .strobes (strobes),
    .sdSample(sdSample),
    .running (running),
    .sckOut  (sckOut),
    .wsOut   (wsOut),
    .wordNo  (wordNo),
    .idle    (idle)
  );

  sap_datapath #(
    .WORD_BITS(WORD_BITS)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .txWrite (txWrite),
    .txData  (txData),
    .sdSample(sdSample),
    .isTx    (isTx),
    .running (running),
    .sdOut   (sdOut),
    .rxData  (rxData)
  );

endmodule

// File: tb/test_serial_audio_port.sv
`timescale 1ns/1ps
module test_serial_audio_port;

  localparam int WB = 32;
  localparam int H  = 2;   // master half bit, system clocks
  localparam int SH = 4;   // slave half bit driven by the bench

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, isMaster = 1'b0, isTx = 1'b0;
  logic sckIn = 1'b0, wsIn = 1'b0;
  logic txWrite, sdIn;
  logic [WB-1:0] txData;
  logic [WB-1:0] rxData;
  logic wordNo, idle, sckOut, wsOut, sdOut;

  // master-phase and slave-phase stimulus, selected by mode
  logic mstWr = 1'b0, slvWr = 1'b0, mstSd = 1'b0, slvSd = 1'b0;
  logic [WB-1:0] mstWrData = '0, slvWrData = '0;
  assign txWrite = isMaster ? mstWr : slvWr;
  assign txData  = isMaster ? mstWrData : slvWrData;
  assign sdIn    = isMaster ? mstSd : slvSd;

  int checks = 0, errors = 0;
  bit cmpOn = 0, done = 0;

  always #4 clk = !clk;  // 125 MHz

  serial_audio_port i_serial_audio_port (
    .clk(clk), .rstN(rstN), .enable(enable), .isMaster(isMaster), .isTx(isTx),
    .txWrite(txWrite), .txData(txData), .rxData(rxData), .wordNo(wordNo),
    .idle(idle), .sckOut(sckOut), .wsOut(wsOut), .sdOut(sdOut),
    .sckIn(sckIn), .wsIn(wsIn), .sdIn(sdIn)
  );

  function automatic logic [WB-1:0] txPat(input int n);
    return 32'hC001_D00D ^ (32'(n) * 32'h0246_8ACF);
  endfunction
  function automatic logic [WB-1:0] rxPat(input int n);
    return 32'hA5C3_0F96 ^ (32'(n) * 32'h1357_9BDF);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [WB-1:0] act, input logic [WB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model for master mode, advanced on every rising clock
  bit mRun = 0;
  int t = 0, k = 0;
  logic [WB-1:0] txRegM = '0, curTx = '0, expRx = '0;
  logic expWordNo = 1'b1, expIdle = 1'b1;

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; t = 0; k = 0; txRegM = '0; curTx = '0; expRx = '0;
      expWordNo = 1'b1; expIdle = 1'b1;
    end else begin
      if (isMaster) begin
        if (mRun) begin
          t++;
          if (t == WB * 2 * H) begin
            if (!isTx) begin expRx = rxPat(k); expWordNo = ((k % 2) == 1); end
            if (enable) begin
              k++; t = 0; curTx = txRegM;
              if (isTx) expWordNo = ((k % 2) == 0);
            end else begin
              mRun = 0; expIdle = 1'b1;
            end
          end
        end else if (enable) begin
          mRun = 1; t = 0; k = 0; curTx = txRegM; expIdle = 1'b0;
          if (isTx) expWordNo = 1'b1;
        end
      end
      if (txWrite) txRegM = txData;
    end
  end

  // Master-mode stimulus from the model's position in the frame
  always @(negedge clk) begin : mstDrive
    logic [WB-1:0] w;
    w = rxPat(k);
    if (mRun) begin
      mstSd     <= w[WB-1 - t/(2*H)];
      mstWr     <= isTx && (t == 10);
      mstWrData <= txPat(k + 1);
    end else begin
      mstSd     <= 1'b0;
      mstWr     <= 1'b1;
      mstWrData <= txPat(0);
    end
  end

  // Per-clock comparison
  always @(negedge clk) begin : cmpBlk
    logic expSck, expWs, expSd;
    if (cmpOn && rstN) begin
      if (isMaster) begin
        expSck = mRun && ((t % (2*H)) >= H);
        expWs  = mRun && ((k % 2) == 1);
        expSd  = (mRun && isTx) ? curTx[WB-1 - t/(2*H)] : 1'b0;
        chk("R2", "sckOut", WB'(sckOut), WB'(expSck));
        chk("R2", "wsOut", WB'(wsOut), WB'(expWs));
        chk(isTx ? "R3" : "R11", "sdOut", WB'(sdOut), WB'(expSd));
        chk("R8", "idle", WB'(idle), WB'(expIdle));
        chk(isTx ? "R6" : "R5", "wordNo", WB'(wordNo), WB'(expWordNo));
        chk("R4", "rxData", rxData, expRx);
      end else begin
        chk("R11", "slave sckOut", WB'(sckOut), '0);
        chk("R11", "slave wsOut", WB'(wsOut), '0);
      end
    end
  end

  task automatic runMaster(input logic tx, input int n);
    @(negedge clk);
    isMaster = 1'b1; isTx = tx;
    repeat (4) @(negedge clk);
    enable = 1'b1;
    while (!(mRun && k == n - 1 && t == 100)) @(negedge clk);
    enable = 1'b0;
    while (mRun) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic runSlave(input logic tx, input int n, input int stopBit);
    logic [WB-1:0] w, tw;
    @(negedge clk);
    isMaster = 1'b0; isTx = tx;
    slvWrData = txPat(0); slvWr = 1'b1;
    @(negedge clk);
    slvWr = 1'b0;
    enable = 1'b1;
    for (int i = 0; i < 3; i++) begin
      sckIn = 1'b0; wsIn = 1'b1; slvSd = 1'b0;
      repeat (SH) @(negedge clk);
      sckIn = 1'b1;
      repeat (SH) @(negedge clk);
    end
    chk("R9", "idle before frame start", WB'(idle), WB'(1));
    for (int kk = 0; kk < n; kk++) begin
      w  = rxPat(kk);
      tw = txPat(kk);
      for (int b = 0; b < WB; b++) begin
        sckIn = 1'b0; wsIn = ((kk % 2) == 1); slvSd = w[WB-1-b];
        if (b == 10) begin slvWrData = txPat(kk + 1); slvWr = 1'b1; end
        @(negedge clk);
        slvWr = 1'b0;
        repeat (SH - 1) @(negedge clk);
        if (tx) chk("R3", "slave sdOut bit", WB'(sdOut), WB'(tw[WB-1-b]));
        if (tx && b == 5) chk("R6", "slave tx wordNo", WB'(wordNo), WB'((kk % 2) == 0));
        if (!tx && b == 0 && kk > 0) begin
          chk("R4", "slave rxData", rxData, rxPat(kk - 1));
          chk("R5", "slave rx wordNo", WB'(wordNo), WB'((kk - 1) % 2));
        end
        if (b == 2) chk("R7", "idle while active", WB'(idle), '0);
        if (kk == n - 1 && ((stopBit < 0 && b == 16) || b == stopBit)) enable = 1'b0;
        sckIn = 1'b1;
        repeat (SH) @(negedge clk);
        if (b == stopBit) begin
          repeat (60) @(negedge clk);
          chk("R10", "idle with clock held mid-word", WB'(idle), '0);
        end
      end
    end
    sckIn = 1'b0; wsIn = ((n % 2) == 1); slvSd = 1'b0;
    repeat (SH) @(negedge clk);
    if (!tx) begin
      chk("R4", "slave final rxData", rxData, rxPat(n - 1));
      chk("R5", "slave final wordNo", WB'(wordNo), WB'((n - 1) % 2));
    end
    chk("R8", "idle after last word", WB'(idle), WB'(1));
    repeat (4) @(negedge clk);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reset idle", WB'(idle), WB'(1));
    chk("R1", "reset wordNo", WB'(wordNo), WB'(1));
    chk("R1", "reset sckOut", WB'(sckOut), '0);
    chk("R1", "reset wsOut", WB'(wsOut), '0);
    chk("R1", "reset sdOut", WB'(sdOut), '0);
    chk("R1", "reset rxData", rxData, '0);
    cmpOn = 1;
    runMaster(1'b1, 3);
    runMaster(1'b0, 2);
    runMaster(1'b1, 1);
    runSlave(1'b0, 2, -1);
    runSlave(1'b1, 2, -1);
    runSlave(1'b0, 1, 9);
    finish();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    finish();
  end

endmodule